// File: doc/BRIEF.md
# Virtual Output Queue Depth Tracker

This block keeps the switch core's view of how many cells wait in each virtual output queue of an N-port cell switch. There is one saturating counter for every (ingress, egress) pair. Ingress ports post request messages, one lane per ingress port. Each message names the queue that has just taken in a cell, and the matching counter goes up by one. The scheduler reads the full count matrix and a non-empty vector. Once per cell time it returns the set of winning queues together with a tick.

On that tick the tracker decrements the winning counters. In the next cycle it emits one grant per winning ingress port, which names the egress queue that was picked. Requests and grant decrements act on the same counters at the same time. A collision on one counter leaves that counter unchanged.

Top module: `vq_depth_tracker`

## Requirements
- R1: While reset is held and right after it, every counter reads zero, `nonempty` is all zero, no grant is valid and `ovf_pulse` is low.
- R2: A valid request on lane i carrying index `q = i*N + e` increments counter q by one, visible the next cycle. All N lanes may post in the same cycle.
- R3: A request on lane i whose index lies outside `i*N .. i*N+N-1` is dropped, and no counter changes because of it.
- R4: When `cell_tick` is high, every queue whose `win_mask` bit is set and whose count is non-zero is decremented by one, visible the next cycle.
- R5: A set `win_mask` bit on a queue with count zero has no effect: the count stays zero and no grant is issued for it.
- R6: If a request and a tick decrement hit the same counter in the same cycle, that counter keeps its value and no overflow is flagged.
- R7: Counters saturate at 2^CW-1. A request to a full counter without a same-cycle decrement leaves the value unchanged and raises `ovf_pulse` for exactly the next cycle.
- R8: In the cycle after a tick, `gnt_valid[i]` is high for exactly one cycle for each ingress i that has a decremented winning queue. Lane i of `gnt_egress` then holds that queue's egress number e. If a row has several winners, the lowest e is reported. No grant appears without a preceding tick.
- R9: `nonempty[q]` is high exactly when counter q is non-zero.
- R10: While `cell_tick` is low, `win_mask` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N | Request strobe, one bit per ingress lane |
| req_qidx | input | N*QW | Queue index per lane, lane i at bits i*QW |
| cell_tick | input | 1 | Cell-time strobe from the scheduler |
| win_mask | input | N*N | Winning queues, bit i*N+e |
| depth | output | N*N*CW | Count matrix, queue q at bits q*CW |
| nonempty | output | N*N | Count non-zero flags |
| gnt_valid | output | N | Grant strobe per ingress |
| gnt_egress | output | N*EW | Granted egress per ingress, lane i at bits i*EW |
| ovf_pulse | output | 1 | A request hit a full counter |

## Verification
The checker takes it for granted that the scheduler sends at most one winner per ingress row and per egress column. It also assumes the inputs settle clear of the rising edge. The random stimulus builds each tick's winner set from a shuffled permutation with some rows dropped. Requests mostly carry the lane's own ingress field, with a share deliberately pointing at another lane's range. Narrow counters and a request rate above the grant rate drive queues into saturation. Directed steps cover overflow, a collision at a full counter, winners on empty queues and a win mask presented without a tick.

// File: rtl/vq_depth_tracker.sv
`timescale 1ns/1ps
module vq_depth_tracker #(
  parameter int N  = 4,
  parameter int CW = 4,
  localparam int Q  = N * N,
  localparam int QW = $clog2(Q),
  localparam int EW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      req_valid,
  input  logic [N*QW-1:0]   req_qidx,
  input  logic              cell_tick,
  input  logic [Q-1:0]      win_mask,
  output logic [Q*CW-1:0]   depth,
  output logic [Q-1:0]      nonempty,
  output logic [N-1:0]      gnt_valid,
  output logic [N*EW-1:0]   gnt_egress,
  output logic              ovf_pulse
);
  localparam logic [CW-1:0] FULL = '1;

  logic [Q-1:0]    hit, take, full_hit;
  logic [N-1:0]    row_any;
  logic [N*EW-1:0] row_sel;

  always_comb begin
    hit = '0;
    for (int i = 0; i < N; i++) begin
      if (req_valid[i] && int'(req_qidx[i*QW +: QW]) >= i*N
          && int'(req_qidx[i*QW +: QW]) < i*N + N)
        hit[req_qidx[i*QW +: QW]] = 1'b1;
    end
  end

  assign take = {Q{cell_tick}} & win_mask & nonempty;

  for (genvar q = 0; q < Q; q++) begin : g_q
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  cnt <= '0;
      else if (hit[q] && !take[q] && cnt != FULL)  cnt <= cnt + 1'b1;
      else if (take[q] && !hit[q])                 cnt <= cnt - 1'b1;
    end
    assign depth[q*CW +: CW] = cnt;
    assign nonempty[q]       = cnt != '0;
    assign full_hit[q]       = hit[q] && !take[q] && cnt == FULL;
  end

  always_comb begin
    row_any = '0;
    row_sel = '0;
    for (int i = 0; i < N; i++) begin
      for (int e = N - 1; e >= 0; e--) begin
        if (take[i*N + e]) begin
          row_any[i]            = 1'b1;
          row_sel[i*EW +: EW]   = EW'(e);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_valid  <= '0;
      gnt_egress <= '0;
      ovf_pulse  <= 1'b0;
    end else begin
      gnt_valid  <= row_any;
      gnt_egress <= row_sel;
      ovf_pulse  <= |full_hit;
    end
  end
endmodule

// File: rtl/vq_depth_chk.sv
`timescale 1ns/1ps
module vq_depth_chk #(
  parameter int N  = 4,
  parameter int CW = 4,
  localparam int Q  = N * N,
  localparam int QW = $clog2(Q),
  localparam int EW = $clog2(N)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      req_valid,
  input logic [N*QW-1:0]   req_qidx,
  input logic              cell_tick,
  input logic [Q-1:0]      win_mask,
  input logic [Q*CW-1:0]   depth,
  input logic [Q-1:0]      nonempty,
  input logic [N-1:0]      gnt_valid,
  input logic [N*EW-1:0]   gnt_egress,
  input logic              ovf_pulse
);
  logic [Q-1:0] inc_seen, full_now;

  always_comb begin
    inc_seen = '0;
    for (int i = 0; i < N; i++)
      for (int e = 0; e < N; e++)
        if (req_valid[i] && int'(req_qidx[i*QW +: QW]) == i*N + e)
          inc_seen[i*N + e] = 1'b1;
  end

  for (genvar q = 0; q < Q; q++) begin : g_c
    assign full_now[q] = &depth[q*CW +: CW];

    // R2
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_seen[q] && !(cell_tick && win_mask[q]) && !full_now[q])
      |=> depth[q*CW +: CW] == $past(depth[q*CW +: CW]) + 1'b1);

    // R4
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_tick && win_mask[q] && nonempty[q] && !inc_seen[q])
      |=> depth[q*CW +: CW] == $past(depth[q*CW +: CW]) - 1'b1);

    // R6
    collide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_tick && win_mask[q] && nonempty[q] && inc_seen[q])
      |=> $stable(depth[q*CW +: CW]));

    // R5
    empty_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!nonempty[q] && !inc_seen[q]) |=> !nonempty[q]);
  end

  // R8
  grant_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt_valid) |-> $past(cell_tick));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> $past(|(inc_seen & full_now)));
endmodule

bind vq_depth_tracker vq_depth_chk #(.N(N), .CW(CW)) chk_i (.*);

// File: tb/vq_depth_tracker_test.sv
`timescale 1ns/1ps
module vq_depth_tracker_test;
  localparam int N  = 4;
  localparam int CW = 4;
  localparam int Q  = N * N;
  localparam int QW = $clog2(Q);
  localparam int EW = $clog2(N);
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] req_valid = '0;
  logic [N*QW-1:0] req_qidx = '0;
  logic cell_tick = 1'b0;
  logic [Q-1:0] win_mask = '0;
  logic [Q*CW-1:0] depth;
  logic [Q-1:0] nonempty;
  logic [N-1:0] gnt_valid;
  logic [N*EW-1:0] gnt_egress;
  logic ovf_pulse;

  int compared = 0, mismatched = 0;
  int m [Q];

  always #2.5 clk = ~clk;

  vq_depth_tracker #(.N(N), .CW(CW)) uut (.*);

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [QW-1:0] qi(input int i, input int e);
    return QW'(i * N + e);
  endfunction

  task automatic step(input string tag, input logic [N-1:0] rv, input logic [N*QW-1:0] ri,
                      input logic tk, input logic [Q-1:0] wm);
    logic [Q-1:0] h, t;
    logic [N-1:0] ev;
    logic [N*EW-1:0] eg;
    logic eo;
    logic [Q*CW-1:0] ed;
    logic [Q-1:0] en;
    req_valid = rv; req_qidx = ri; cell_tick = tk; win_mask = wm;
    h = '0; t = '0; ev = '0; eg = '0; eo = 1'b0;
    for (int i = 0; i < N; i++) begin
      int x = int'(ri[i*QW +: QW]);
      if (rv[i] && x / N == i && x < Q) h[x] = 1'b1;
    end
    for (int q = 0; q < Q; q++) t[q] = tk && wm[q] && m[q] != 0;
    for (int i = 0; i < N; i++)
      for (int e = N - 1; e >= 0; e--)
        if (t[i*N + e]) begin ev[i] = 1'b1; eg[i*EW +: EW] = EW'(e); end
    for (int q = 0; q < Q; q++) begin
      if (h[q] && !t[q]) begin
        if (m[q] == MAXC) eo = 1'b1; else m[q]++;
      end else if (t[q] && !h[q]) m[q]--;
    end
    for (int q = 0; q < Q; q++) begin
      ed[q*CW +: CW] = CW'(m[q]);
      en[q] = m[q] != 0;
    end
    @(negedge clk);
    chk({tag, " R2/R3/R4/R6 depth"}, 256'(depth), 256'(ed));
    chk({tag, " R9 nonempty"}, 256'(nonempty), 256'(en));
    chk({tag, " R8 gnt_valid"}, 256'(gnt_valid), 256'(ev));
    chk({tag, " R8 gnt_egress"}, 256'(gnt_egress), 256'(eg));
    chk({tag, " R7 ovf_pulse"}, 256'(ovf_pulse), 256'(eo));
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [N*QW-1:0] ri;
    logic [Q-1:0] wm;
    for (int q = 0; q < Q; q++) m[q] = 0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 depth in reset", 256'(depth), 256'(0));
    chk("R1 gnt in reset", 256'(gnt_valid), 256'(0));
    chk("R1 ovf in reset", 256'(ovf_pulse), 256'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 depth after reset", 256'(depth), 256'(0));
    chk("R1 nonempty after reset", 256'(nonempty), 256'(0));

    ri = '0; ri[1*QW +: QW] = qi(1, 2);
    for (int k = 0; k < MAXC; k++) step("R2 fill", 4'b0010, ri, 1'b0, '0);
    step("R7 overflow", 4'b0010, ri, 1'b0, '0);
    step("R7 pulse ends", '0, '0, 1'b0, '0);
    wm = '0; wm[1*N + 2] = 1'b1;
    step("R6 collide at full", 4'b0010, ri, 1'b1, wm);
    step("R4 R8 decrement", '0, '0, 1'b1, wm);
    step("R10 mask without tick", '0, '0, 1'b0, wm);
    wm = '0; wm[0] = 1'b1; wm[2*N + 3] = 1'b1;
    step("R5 win on empty", '0, '0, 1'b1, wm);
    ri = '0; ri[0 +: QW] = qi(1, 2); ri[3*QW +: QW] = qi(0, 1);
    step("R3 foreign lane", 4'b1001, ri, 1'b0, '0);
    ri = '0;
    for (int i = 0; i < N; i++) ri[i*QW +: QW] = qi(i, N - 1 - i);
    step("R2 all lanes", '1, ri, 1'b0, '0);

    for (int n = 0; n < 4000; n++) begin
      int p [N];
      logic [N-1:0] rv;
      for (int i = 0; i < N; i++) p[i] = i;
      for (int i = N - 1; i > 0; i--) begin
        int j = int'($urandom % (i + 1));
        int tmp = p[i]; p[i] = p[j]; p[j] = tmp;
      end
      wm = '0;
      for (int i = 0; i < N; i++) if ($urandom % 4 != 0) wm[i*N + p[i]] = 1'b1;
      rv = '0; ri = '0;
      for (int i = 0; i < N; i++) begin
        rv[i] = ($urandom % 3) != 0;
        if ($urandom % 8 == 0) ri[i*QW +: QW] = QW'($urandom % Q);
        else ri[i*QW +: QW] = qi(i, int'($urandom % 2));
      end
      step("random", rv, ri, ($urandom % 3) == 0, wm);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule